// File: doc/BRIEF.md
# Inhibitable Serial-Out Shift Register

This block is an eight-stage shift register with one serial output. Each cycle it can capture a whole parallel word, move its contents one stage towards the output while a serial bit enters the first stage, or keep every stage as it is. A mode pin chooses between capture and shifting. An inhibit pin pauses the register while the system clock keeps running. The output shows only the last stage, so a captured word leaves on `q_last` starting from its top bit.

The block runs on one free-running clock. The inhibit pin is sampled on each rising edge as an active-high hold and never gates the clock. An active-low clear zeroes every stage at once, with no clock edge needed. The end of the clear passes through a short synchronizer, so the register starts again on a known edge.

The decoded operation is an enumeration with three values. OP_HOLD applies when inhibit is high, whatever the mode. OP_LOAD applies when inhibit is low and the mode pin is low. OP_SHIFT applies when inhibit is low and the mode pin is high. The register moves from clear to running when the synchronized clear goes high. On each rising edge after that it performs the operation decoded for that edge.

Top module: `piso_shift_reg`

## Requirements
- R1: While `clr_n` is low, all stages are zero and `q_last` is 0. This takes effect as soon as `clr_n` falls, without waiting for a clock edge, and whatever the other inputs are.
- R2: After `clr_n` goes high, the first SYNC_STAGES rising edges (default 2) leave the register at zero. The edge after them is the first that loads, shifts or holds.
- R3: On an edge with `inhibit` at 0 and `shift_en` at 1, stage k takes the old value of stage k-1 for k from 1 to 7, and stage 0 takes `ser_in`.
- R4: On an edge with `inhibit` at 0 and `shift_en` at 0, stage k takes `par_in[k]`, and `ser_in` has no effect.
- R5: After a load followed by seven shifts, `q_last` shows `par_in[7]`, then `par_in[6]`, and so on down to `par_in[0]`, one bit per edge.
- R6: On an edge with `inhibit` at 1, no stage changes, whatever `shift_en`, `ser_in` and `par_in` are.
- R7: `q_last` is always stage 7, the stage loaded from `par_in[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, rising edge active |
| clr_n | input | 1 | Clear, active low. Asserts at once; its release is synchronized |
| inhibit | input | 1 | 1 holds the register on this edge |
| shift_en | input | 1 | 1 selects shifting, 0 selects parallel capture |
| ser_in | input | 1 | Serial bit that enters stage 0 on a shift |
| par_in | input | 8 | Parallel word; bit k goes to stage k |
| q_last | output | 1 | Value of stage 7 |

## Verification
The hardest cases are the clear and its release. The clear must empty the register in the middle of a shift, between two edges. After that, loads must stay without effect for exactly the edges the synchronizer takes. The bench drops `clr_n` half a nanosecond after an edge, while `q_last` shows a 1, and checks the output before the next edge. It then holds a word of all ones at the inputs with a load pending across the release, which shows the edge where the register restarts. A behavioural model then follows random mode, inhibit and data patterns and is compared on every clock.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

endpackage

// File: rtl/piso_clr_sync.sv
module piso_clr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic rst_n
);
    localparam logic [SYNC_STAGES-1:0] FILL_ONE = {{(SYNC_STAGES-1){1'b0}}, 1'b1};

    logic [SYNC_STAGES-1:0] chain_q;

    // Clear assertion is asynchronous; its release ripples through the chain.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= (chain_q << 1) | FILL_ONE;
        end
    end

    assign rst_n = chain_q[SYNC_STAGES-1];

    // R2
    release_after_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(rst_n) |-> $past(clr_n));

endmodule

// File: rtl/piso_op_decode.sv
module piso_op_decode
    import piso_pkg::*;
(
    input  logic     inhibit,
    input  logic     shift_en,
    output piso_op_e op
);
    // Inhibit wins over the mode pin; it acts as a synchronous hold.
    always_comb begin
        unique case ({inhibit, shift_en})
            2'b00:   op = OP_LOAD;
            2'b01:   op = OP_SHIFT;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/piso_stage_core.sv
module piso_stage_core
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  piso_op_e         op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_last
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] stages_q;
    logic [WIDTH-1:0] stages_d;

    always_comb begin
        unique case (op)
            OP_LOAD:  stages_d = par_in;
            OP_SHIFT: stages_d = {stages_q[LAST-1:0], ser_in};
            OP_HOLD:  stages_d = stages_q;
            default:  stages_d = stages_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stages_q <= '0;
        end else begin
            stages_q <= stages_d;
        end
    end

    always_comb begin
        q_last = stages_q[LAST];
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            clear_zero_chk: assert (stages_q == '0);
        end
    end

    // R6
    hold_on_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_HOLD) |-> stages_q == $past(stages_q));

    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_SHIFT)
            |-> stages_q == {$past(stages_q[LAST-1:0]), $past(ser_in)});

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == OP_LOAD) |-> stages_q == $past(par_in));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             inhibit,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             q_last
);
    logic     rst_n;
    piso_op_e op;

    piso_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .rst_n (rst_n)
    );

    piso_op_decode i_dec (
        .inhibit  (inhibit),
        .shift_en (shift_en),
        .op       (op)
    );

    piso_stage_core #(.WIDTH(WIDTH)) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ser_in (ser_in),
        .par_in (par_in),
        .q_last (q_last)
    );

endmodule

// File: tb/test_piso_shift_reg.sv
`timescale 1ns/1ps
module test_piso_shift_reg;
    localparam int W    = 8;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         inhibit;
    logic         shift_en;
    logic         ser_in;
    logic [W-1:0] par_in;
    logic         q_last;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase  = "R1 reset";

    logic [W-1:0] model;
    int           wake;

    piso_shift_reg #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_piso_shift_reg (
        .clk(clk), .clr_n(clr_n), .inhibit(inhibit), .shift_en(shift_en),
        .ser_in(ser_in), .par_in(par_in), .q_last(q_last)
    );

    always #2 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (q_last !== exp) begin
            errors++;
            $display("FAIL %s: q_last=%b expected %b at %0t", tag, q_last, exp, $time);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            model <= '0;
            wake  <= 0;
        end else if (wake < SYNC) begin
            wake <= wake + 1;
        end else if (!inhibit) begin
            if (shift_en) model <= {model[W-2:0], ser_in};
            else          model <= par_in;
        end
    end

    always @(negedge clk) begin
        check(model[W-1], phase);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            report();
        end
    end

    task automatic step(input logic inh, input logic sh, input logic s, input logic [W-1:0] p);
        inhibit = inh; shift_en = sh; ser_in = s; par_in = p;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] word;
        clr_n = 1'b0; inhibit = 1'b0; shift_en = 1'b0; ser_in = 1'b0; par_in = '1;
        #1 check(1'b0, "R1 reset state");
        repeat (3) @(negedge clk);
        check(1'b0, "R1 clear ignores load");

        // R2: release with a load of all ones pending
        phase = "R2 release";
        clr_n = 1'b1;
        for (int i = 0; i < SYNC; i++) begin
            step(1'b0, 1'b0, 1'b0, 8'hFF);
            check(1'b0, "R2 edge ignored after release");
        end
        step(1'b0, 1'b0, 1'b0, 8'hFF);
        check(1'b1, "R2 first active edge");

        // R7: output is stage 7
        phase = "R7 last stage";
        step(1'b0, 1'b0, 1'b0, 8'h7F);
        check(1'b0, "R7 load 7F");
        step(1'b0, 1'b0, 1'b0, 8'h80);
        check(1'b1, "R7 load 80");

        // R5: load then shift out, top bit first
        phase = "R5 shift out";
        word = 8'hB4;
        step(1'b0, 1'b0, 1'b0, word);
        check(word[7], "R5 bit 7");
        for (int k = 6; k >= 0; k--) begin
            step(1'b0, 1'b1, 1'b0, 8'h00);
            check(word[k], "R5 shifted bit");
        end

        // R3: serial bits travel to the output after eight shifts
        phase = "R3 serial path";
        step(1'b0, 1'b1, 1'b1, 8'h00);
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b0, 8'h00);
        check(1'b1, "R3 serial bit reached stage 7");

        // R4: serial input ignored during a load
        phase = "R4 load ignores serial";
        step(1'b0, 1'b0, 1'b1, 8'h00);
        for (int k = 0; k < 7; k++) begin
            step(1'b0, 1'b1, 1'b0, 8'h00);
            check(1'b0, "R4 no serial bit captured on load");
        end

        // R6: inhibit holds against load and shift
        phase = "R6 inhibit";
        step(1'b0, 1'b0, 1'b0, 8'hC0);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, k[0], 1'b0, 8'h00);
            check(1'b1, "R6 hold with inhibit");
        end
        step(1'b0, 1'b1, 1'b0, 8'h00);
        check(1'b1, "R6 resumed shift");
        step(1'b0, 1'b1, 1'b0, 8'h00);
        check(1'b0, "R6 second shift");

        // R1: clear asserted between edges while output is 1
        phase = "R1 mid-shift clear";
        step(1'b0, 1'b0, 1'b0, 8'hFF);
        step(1'b0, 1'b1, 1'b1, 8'h00);
        @(posedge clk);
        #0.5 clr_n = 1'b0;
        #0.5 check(1'b0, "R1 immediate clear");
        @(negedge clk);
        clr_n = 1'b1;

        // R3 R4 R6: random patterns against the model
        phase = "R3 R4 R6 random";
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) == 0, ($urandom % 3) != 0, 1'($urandom), 8'($urandom));
        end
        report();
    end

endmodule